// File: doc/BRIEF.md
# Quadrature Position Counter Core

This block turns two already-cleaned encoder phase signals into a signed position count. Each clock it samples the pair, compares it with the pair seen on the previous clock, and decides whether the shaft moved one step forward, one step back, or made an illegal jump. The position counter can run free over its full width or wrap between a lower bound (the init value) and an upper bound (the modulus). A revolution counter, a compare output, a no-motion watchdog and a set of sticky event flags with per-flag interrupt enables are built around it.

The decoder is a four-state machine. Its states are the four phase pairs {A,B}: `PH_00`, `PH_10`, `PH_11` and `PH_01`. The forward transitions are `PH_00`→`PH_10`→`PH_11`→`PH_01`→`PH_00`. The backward transitions run the same ring in the other direction. The diagonal transitions (`PH_00`↔`PH_11`, `PH_10`↔`PH_01`) are illegal. A transition to the same state is idle. In single-phase mode the same state register is used, but only a rising A counts, and B gives the direction.

An index input and a home input each pass through an edge detector with its own enable and polarity. A detected edge raises a flag, and when enabled it reloads the position from the init value. A software load pulse does the same reload. The state machine resets to `PH_00`, so the phases should be low while reset is applied.

Top module: `qpc_core`

## Requirements
- R1: After reset, position, pos_diff, revolution, last_dir, flags and irq are all zero, and cmp_match is low while cmp_val differs from zero.
- R2: In quadrature mode, with {A,B} stepping 00→10→11→01→00, each step adds one to position and sets last_dir to 1. The reverse order subtracts one per step and clears last_dir. Position changes at the first clock edge that samples the new phase pair.
- R3: In quadrature mode, a change of both phases in one sample leaves position and last_dir unchanged. In either mode, such a change sets flag bit 4.
- R4: In single-phase mode, only a rising edge of A counts: up when B is 0, down when B is 1. A falling A and changes of B alone do not count.
- R5: cfg_reverse swaps up and down counting in both modes, including the value written to last_dir.
- R6: With cfg_modulo_en set, an up step from position == mod_val loads init_val and sets flag bit 5. A down step from position == init_val loads mod_val and sets flag bit 6.
- R7: With cfg_rev_on_wrap clear, each selected index edge adds one to revolution if last_dir is 1 and subtracts one if it is 0. With cfg_rev_on_wrap set, a modulus roll-over adds one and a roll-under subtracts one.
- R8: When enabled, index and home each detect a rising edge, or a falling edge when their fall-select bit is set. A detected edge sets flag bit 0 (index) or bit 1 (home), and loads init_val into position when the matching load bit is set. The opposite edge does nothing.
- R9: A one-cycle sw_load pulse copies init_val into position at that clock edge.
- R10: In equality mode, cmp_match is high while position equals cmp_val. In read mode (cfg_cmp_on_read), cmp_match is high for the cycle after a pos_read pulse. Flag bit 3 is set on the clock edge after cmp_match is high.
- R11: With the watchdog enabled and a timeout T of 1 or more, flag bit 2 is set at the T-th consecutive clock edge without a counted step. Any counted step restarts the count. A timeout of 0 never fires.
- R12: Flags stay set until the matching flag_clr bit is high at a clock edge. A new event in the same cycle wins over the clear. irq equals flags AND irq_en.
- R13: pos_diff holds the net count of steps since the last pos_read. On a pos_read cycle it restarts from that cycle's own step (−1, 0 or +1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Filtered phase A |
| phase_b | input | 1 | Filtered phase B |
| index_in | input | 1 | Filtered index input |
| home_in | input | 1 | Filtered home input |
| cfg_single | input | 1 | 1 = single-phase count mode, 0 = quadrature mode |
| cfg_reverse | input | 1 | Swap counting direction |
| cfg_modulo_en | input | 1 | Wrap between init_val and mod_val |
| cfg_rev_on_wrap | input | 1 | Revolution counter steps on modulus wrap instead of on index |
| cfg_index_en | input | 1 | Enable index edge detection |
| cfg_index_fall | input | 1 | Index detects falling edges |
| cfg_index_load | input | 1 | Index edge loads init_val |
| cfg_home_en | input | 1 | Enable home edge detection |
| cfg_home_fall | input | 1 | Home detects falling edges |
| cfg_home_load | input | 1 | Home edge loads init_val |
| cfg_cmp_on_read | input | 1 | Compare output follows pos_read instead of equality |
| cfg_wdog_en | input | 1 | Enable no-motion watchdog |
| cfg_wdog_timeout | input | 16 | Watchdog timeout in clocks |
| init_val | input | 32 | Initial / lower wrap value |
| mod_val | input | 32 | Modulus / upper wrap value |
| cmp_val | input | 32 | Compare value |
| sw_load | input | 1 | Load init_val into position |
| pos_read | input | 1 | A position read is taking place |
| flag_clr | input | 7 | Per-flag clear strobes |
| irq_en | input | 7 | Per-flag interrupt enables |
| position | output | 32 | Position counter |
| pos_diff | output | 16 | Net steps since the last read |
| revolution | output | 16 | Revolution counter |
| last_dir | output | 1 | Direction of the last counted step, 1 = up |
| cmp_match | output | 1 | Compare output |
| flags | output | 7 | Sticky flags: 0 index, 1 home, 2 watchdog, 3 compare, 4 both-change, 5 roll-over, 6 roll-under |
| irq | output | 7 | Interrupt requests |

## Verification
The decoder is driven through a table of phase pairs. The table walks the forward ring, then the backward ring, then the same pairs with reverse set, then a diagonal jump, then a single-phase run mixing rising A, falling A and lone B changes. Comparing position and last_dir after each pair tells a correct ring direction apart from a mirrored one. It also shows that an illegal jump counts nothing and that only rising A counts in single-phase mode. Directed sequences then check each feature at its boundary:
- modulus wrap in both directions
- the compare output in both of its modes
- index and home edge polarity
- the exact watchdog edge

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } qpc_phase_e;

    localparam int NFLAG       = 7;
    localparam int FL_INDEX    = 0;
    localparam int FL_HOME     = 1;
    localparam int FL_WDOG     = 2;
    localparam int FL_CMP      = 3;
    localparam int FL_BOTH     = 4;
    localparam int FL_ROLLOVER = 5;
    localparam int FL_ROLLUNDR = 6;
endpackage

// File: rtl/qpc_phase_fsm.sv
module qpc_phase_fsm
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    input  logic single_mode,
    input  logic reverse,
    output logic step_up,
    output logic step_dn,
    output logic both_chg
);
    qpc_phase_e st_q;
    qpc_phase_e smp;
    logic [1:0] prev_ab;
    logic [1:0] cur_ab;
    logic       fwd;
    logic       bwd;

    assign smp     = qpc_phase_e'({ph_a, ph_b});
    assign prev_ab = st_q;
    assign cur_ab  = {ph_a, ph_b};

    // state register: holds the last sampled phase pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_00;
        else        st_q <= smp;
    end

    // output decode from state and the new sample
    always_comb begin
        fwd = 1'b0;
        bwd = 1'b0;
        if (single_mode) begin
            fwd = !prev_ab[1] && ph_a && !ph_b;
            bwd = !prev_ab[1] && ph_a &&  ph_b;
        end else begin
            unique case (st_q)
                PH_00: begin fwd = (smp == PH_10); bwd = (smp == PH_01); end
                PH_10: begin fwd = (smp == PH_11); bwd = (smp == PH_00); end
                PH_11: begin fwd = (smp == PH_01); bwd = (smp == PH_10); end
                PH_01: begin fwd = (smp == PH_00); bwd = (smp == PH_11); end
                default: begin fwd = 1'b0; bwd = 1'b0; end
            endcase
        end
        step_up  = reverse ? bwd : fwd;
        step_dn  = reverse ? fwd : bwd;
        both_chg = (prev_ab[1] != cur_ab[1]) && (prev_ab[0] != cur_ab[0]);
    end

    // R3: a diagonal jump in quadrature mode never counts
    a_r3_no_count_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && (prev_ab == ~cur_ab)) |-> !(step_up || step_dn));

    // R4: single-phase mode counts only while A is high after being low
    a_r4_single_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && (step_up || step_dn)) |-> (ph_a && !prev_ab[1]));
endmodule

// File: rtl/qpc_edge_det.sv
module qpc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic en_i,
    input  logic fall_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign edge_o = en_i && (fall_i ? (prev_q && !sig_i) : (!prev_q && sig_i));

    // R8: a reported edge always goes with a change of the input
    a_r8_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (sig_i != prev_q));
endmodule

// File: rtl/qpc_core.sv
module qpc_core
    import qpc_pkg::*;
#(
    parameter int POS_W  = 32,
    parameter int DIFF_W = 16,
    parameter int REV_W  = 16,
    parameter int WD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              index_in,
    input  logic              home_in,
    input  logic              cfg_single,
    input  logic              cfg_reverse,
    input  logic              cfg_modulo_en,
    input  logic              cfg_rev_on_wrap,
    input  logic              cfg_index_en,
    input  logic              cfg_index_fall,
    input  logic              cfg_index_load,
    input  logic              cfg_home_en,
    input  logic              cfg_home_fall,
    input  logic              cfg_home_load,
    input  logic              cfg_cmp_on_read,
    input  logic              cfg_wdog_en,
    input  logic [WD_W-1:0]   cfg_wdog_timeout,
    input  logic [POS_W-1:0]  init_val,
    input  logic [POS_W-1:0]  mod_val,
    input  logic [POS_W-1:0]  cmp_val,
    input  logic              sw_load,
    input  logic              pos_read,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    output logic [POS_W-1:0]  position,
    output logic [DIFF_W-1:0] pos_diff,
    output logic [REV_W-1:0]  revolution,
    output logic              last_dir,
    output logic              cmp_match,
    output logic [NFLAG-1:0]  flags,
    output logic [NFLAG-1:0]  irq
);
    localparam int NTRIG = 2;

    logic             step_up, step_dn, both_chg, any_step;
    logic [NTRIG-1:0] trig_sig, trig_en, trig_fall, trig_edge;
    logic             idx_edge, home_edge, load_any;
    logic             wrap_up, wrap_dn, set_ro, set_ru;
    logic             rev_inc, rev_dec, wd_fire, read_q;
    logic [WD_W-1:0]  wd_cnt;
    logic [NFLAG-1:0] flag_set;
    logic [DIFF_W-1:0] step_val;

    qpc_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ph_a(phase_a), .ph_b(phase_b),
        .single_mode(cfg_single), .reverse(cfg_reverse),
        .step_up(step_up), .step_dn(step_dn), .both_chg(both_chg)
    );

    assign trig_sig  = {home_in,       index_in};
    assign trig_en   = {cfg_home_en,   cfg_index_en};
    assign trig_fall = {cfg_home_fall, cfg_index_fall};

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        qpc_edge_det u_edge (
            .clk(clk), .rst_n(rst_n), .sig_i(trig_sig[g]),
            .en_i(trig_en[g]), .fall_i(trig_fall[g]), .edge_o(trig_edge[g])
        );
    end

    assign idx_edge  = trig_edge[0];
    assign home_edge = trig_edge[1];
    assign any_step  = step_up || step_dn;
    assign load_any  = sw_load || (idx_edge && cfg_index_load) || (home_edge && cfg_home_load);
    assign wrap_up   = cfg_modulo_en && step_up && (position == mod_val);
    assign wrap_dn   = cfg_modulo_en && step_dn && (position == init_val);
    assign set_ro    = wrap_up && !load_any;
    assign set_ru    = wrap_dn && !load_any;
    assign rev_inc   = cfg_rev_on_wrap ? set_ro : (idx_edge && last_dir);
    assign rev_dec   = cfg_rev_on_wrap ? set_ru : (idx_edge && !last_dir);
    assign wd_fire   = cfg_wdog_en && !any_step &&
                       ({1'b0, wd_cnt} + {{WD_W{1'b0}}, 1'b1} == {1'b0, cfg_wdog_timeout});
    assign step_val  = step_up ? DIFF_W'(1) : (step_dn ? {DIFF_W{1'b1}} : '0);

    // position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            position <= '0;
        end else if (load_any) begin
            position <= init_val;
        end else if (step_up) begin
            position <= wrap_up ? init_val : position + POS_W'(1);
        end else if (step_dn) begin
            position <= wrap_dn ? mod_val : position - POS_W'(1);
        end
    end

    // direction, difference, revolution, watchdog, read tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_dir   <= 1'b0;
            pos_diff   <= '0;
            revolution <= '0;
            wd_cnt     <= '0;
            read_q     <= 1'b0;
        end else begin
            if (any_step) last_dir <= step_up;
            pos_diff <= pos_read ? step_val : pos_diff + step_val;
            if (rev_inc)      revolution <= revolution + REV_W'(1);
            else if (rev_dec) revolution <= revolution - REV_W'(1);
            if (!cfg_wdog_en || any_step || wd_fire) wd_cnt <= '0;
            else                                     wd_cnt <= wd_cnt + WD_W'(1);
            read_q <= pos_read;
        end
    end

    assign cmp_match = cfg_cmp_on_read ? read_q : (position == cmp_val);

    always_comb begin
        flag_set              = '0;
        flag_set[FL_INDEX]    = idx_edge;
        flag_set[FL_HOME]     = home_edge;
        flag_set[FL_WDOG]     = wd_fire;
        flag_set[FL_CMP]      = cmp_match;
        flag_set[FL_BOTH]     = both_chg;
        flag_set[FL_ROLLOVER] = set_ro;
        flag_set[FL_ROLLUNDR] = set_ru;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    assign irq = flags & irq_en;

    // R2: a plain up step adds exactly one
    a_r2_up_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load_any && !cfg_modulo_en) |=> (position == $past(position) + POS_W'(1)));

    // R6: an up step at the modulus lands on the init value
    a_r6_wrap_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_modulo_en && step_up && !load_any && (position == mod_val))
        |=> (position == $past(init_val)));

    // R11: the timeout flag only rises after an enabled, motionless cycle
    a_r11_wdog_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_WDOG]) |-> ($past(cfg_wdog_en) && !$past(any_step)));

    // R12: a set flag that is not cleared stays set
    for (genvar f = 0; f < NFLAG; f++) begin : g_sticky
        a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[f] && !flag_clr[f]) |=> flags[f]);
    end
endmodule

// File: tb/sim_qpc_core.sv
`timescale 1ns/1ps
module sim_qpc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 0, phase_b = 0, index_in = 0, home_in = 0;
    logic        cfg_single = 0, cfg_reverse = 0, cfg_modulo_en = 0, cfg_rev_on_wrap = 0;
    logic        cfg_index_en = 0, cfg_index_fall = 0, cfg_index_load = 0;
    logic        cfg_home_en = 0, cfg_home_fall = 0, cfg_home_load = 0;
    logic        cfg_cmp_on_read = 0, cfg_wdog_en = 0;
    logic [15:0] cfg_wdog_timeout = 16'd0;
    logic [31:0] init_val = 32'd0, mod_val = 32'd0, cmp_val = 32'hFFFF_FFFF;
    logic        sw_load = 0, pos_read = 0;
    logic [6:0]  flag_clr = 7'd0, irq_en = 7'd0;
    logic [31:0] position;
    logic [15:0] pos_diff, revolution;
    logic        last_dir, cmp_match;
    logic [6:0]  flags, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    qpc_core u0 (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .home_in(home_in),
        .cfg_single(cfg_single), .cfg_reverse(cfg_reverse),
        .cfg_modulo_en(cfg_modulo_en), .cfg_rev_on_wrap(cfg_rev_on_wrap),
        .cfg_index_en(cfg_index_en), .cfg_index_fall(cfg_index_fall),
        .cfg_index_load(cfg_index_load), .cfg_home_en(cfg_home_en),
        .cfg_home_fall(cfg_home_fall), .cfg_home_load(cfg_home_load),
        .cfg_cmp_on_read(cfg_cmp_on_read), .cfg_wdog_en(cfg_wdog_en),
        .cfg_wdog_timeout(cfg_wdog_timeout), .init_val(init_val),
        .mod_val(mod_val), .cmp_val(cmp_val), .sw_load(sw_load),
        .pos_read(pos_read), .flag_clr(flag_clr), .irq_en(irq_en),
        .position(position), .pos_diff(pos_diff), .revolution(revolution),
        .last_dir(last_dir), .cmp_match(cmp_match), .flags(flags), .irq(irq)
    );

    // {single, reverse, A, B, expected position [7:0] sign-extended, expected last_dir, spare}
    localparam int NVEC = 21;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,1'b0,8'h01,1'b1,1'b0},
        {1'b0,1'b0,1'b1,1'b1,8'h02,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b1,8'h03,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,8'h04,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b1,8'h03,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b1,8'h02,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b0,8'h01,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0},
        {1'b0,1'b1,1'b1,1'b0,8'hFF,1'b0,1'b0},
        {1'b0,1'b1,1'b1,1'b1,8'hFE,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b1,8'hFF,1'b1,1'b0},
        {1'b0,1'b0,1'b1,1'b0,8'hFF,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,8'hFE,1'b0,1'b0},
        {1'b1,1'b0,1'b1,1'b0,8'hFF,1'b1,1'b0},
        {1'b1,1'b0,1'b0,1'b0,8'hFF,1'b1,1'b0},
        {1'b1,1'b0,1'b0,1'b1,8'hFF,1'b1,1'b0},
        {1'b1,1'b0,1'b1,1'b1,8'hFE,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b1,8'hFE,1'b0,1'b0},
        {1'b1,1'b1,1'b1,1'b1,8'hFF,1'b1,1'b0},
        {1'b1,1'b0,1'b0,1'b0,8'hFF,1'b1,1'b0},
        {1'b0,1'b0,1'b0,1'b0,8'hFF,1'b1,1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge: one rising edge passes, returns at the next falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ph(input logic a, input logic b);
        phase_a = a;
        phase_b = b;
        cyc();
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 position", position, 32'd0);
        chk("R1 flags", {25'd0, flags}, 32'd0);
        chk("R1 cmp_match", {31'd0, cmp_match}, 32'd0);
        rst_n = 1'b1;
        cyc();
        chk("R1 revolution/diff/dir", {revolution, pos_diff[14:0], last_dir}, 32'd0);

        // R2 R3 R4 R5 decode table
        for (int i = 0; i < NVEC; i++) begin
            cfg_single  = VEC[i][13];
            cfg_reverse = VEC[i][12];
            ph(VEC[i][11], VEC[i][10]);
            chk("R2/R3/R4/R5 position", position, {{24{VEC[i][9]}}, VEC[i][9:2]});
            chk("R2/R3/R4/R5 last_dir", {31'd0, last_dir}, {31'd0, VEC[i][1]});
        end
        cfg_single = 0;
        cfg_reverse = 0;
        chk("R3 both-change flag", {31'd0, flags[4]}, 32'd1);
        chk("R10 equality at -1 set compare flag", {31'd0, flags[3]}, 32'd1);
        chk("R13 pos_diff net", {16'd0, pos_diff}, 32'h0000_FFFF);

        // R12 clear all
        cmp_val = 32'h0000_1000;
        flag_clr = 7'h7F;
        cyc();
        flag_clr = 7'h00;
        chk("R12 cleared", {25'd0, flags}, 32'd0);

        // R13 + R10 read mode
        cfg_cmp_on_read = 1;
        pos_read = 1;
        cyc();
        pos_read = 0;
        chk("R13 diff after read", {16'd0, pos_diff}, 32'd0);
        chk("R10 read-mode match", {31'd0, cmp_match}, 32'd1);
        cyc();
        chk("R10 read-mode pulse ends", {31'd0, cmp_match}, 32'd0);
        chk("R10 compare flag", {31'd0, flags[3]}, 32'd1);
        cfg_cmp_on_read = 0;
        flag_clr = 7'h7F;
        cyc();
        flag_clr = 7'h00;

        // R9 software load
        init_val = 32'd100;
        sw_load = 1;
        cyc();
        sw_load = 0;
        chk("R9 sw load", position, 32'd100);

        // R6 R7 modulo and wrap-driven revolution
        mod_val = 32'd103;
        cfg_modulo_en = 1;
        cfg_rev_on_wrap = 1;
        ph(1, 0); ph(1, 1); ph(0, 1);
        chk("R6 at modulus", position, 32'd103);
        ph(0, 0);
        chk("R6 roll-over to init", position, 32'd100);
        chk("R6 roll-over flag", {31'd0, flags[5]}, 32'd1);
        chk("R7 wrap revolution up", {16'd0, revolution}, 32'd1);
        ph(0, 1);
        chk("R6 roll-under to modulus", position, 32'd103);
        chk("R6 roll-under flag", {31'd0, flags[6]}, 32'd1);
        chk("R7 wrap revolution down", {16'd0, revolution}, 32'd0);

        // R10 equality mode and R12 irq masking
        cmp_val = 32'd101;
        irq_en = 7'b0001000;
        ph(0, 0);
        ph(1, 0);
        chk("R10 equality match", {31'd0, cmp_match}, 32'd1);
        cyc();
        chk("R10 equality flag", {31'd0, flags[3]}, 32'd1);
        chk("R12 irq masked", {25'd0, irq}, 32'b0001000);
        flag_clr = 7'b0100000;
        cyc();
        flag_clr = 7'd0;
        chk("R12 partial clear", {30'd0, flags[6:5]}, 32'b10);

        // R7 R8 index and home
        cfg_modulo_en = 0;
        cfg_rev_on_wrap = 0;
        cmp_val = 32'h0000_1000;
        init_val = 32'd7;
        cfg_index_en = 1;
        cfg_index_load = 1;
        index_in = 1;
        cyc();
        chk("R8 index load", position, 32'd7);
        chk("R8 index flag", {31'd0, flags[0]}, 32'd1);
        chk("R7 index revolution", {16'd0, revolution}, 32'd2);
        index_in = 0;
        cyc();
        chk("R8 index falling ignored", {16'd0, revolution}, 32'd2);
        cfg_home_en = 1;
        cfg_home_fall = 1;
        home_in = 1;
        cyc();
        chk("R8 home rising ignored", {31'd0, flags[1]}, 32'd0);
        home_in = 0;
        cyc();
        chk("R8 home falling flag", {31'd0, flags[1]}, 32'd1);
        chk("R8 home no load", position, 32'd7);

        // R11 watchdog
        cfg_wdog_timeout = 16'd5;
        cfg_wdog_en = 1;
        repeat (4) cyc();
        chk("R11 before timeout", {31'd0, flags[2]}, 32'd0);
        cyc();
        chk("R11 at timeout", {31'd0, flags[2]}, 32'd1);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule